// File: doc/BRIEF.md
# Hierarchical Depth Tile Cull

This block keeps a coarse depth record for a screen region split into 4x4 pixel tiles. Each tile has one entry, and that entry holds the farthest depth anywhere in the tile. Before a tile is shaded, a query presents the nearest depth the incoming block can reach. The block rejects the whole tile with one compare when that depth lies behind everything already stored there. Smaller depth values are nearer.

After the fine depth stage has resolved a tile, it sends the tile's sixteen final depths on the update port. A pipelined tree of pairwise maximum stages folds them down to one value in four register stages. The result then replaces the coarse entry. While an update for a tile is still in that tree, queries to the same tile are stalled, so a decision never uses a value that is about to be replaced. A synchronous clear resets every entry to the far plane and drops updates that are still in flight.

Top module: `hz_tile_cull`

## Requirements
- R1: After reset every entry holds the far value 24'hFFFFFF, so no query is rejected, and res_valid is low.
- R2: An accepted query is rejected exactly when its unsigned 24-bit minimum depth is strictly greater than the stored entry. An equal value is accepted.
- R3: An update replaces the tile entry with the largest of its 16 depths, where lane i sits at upd_depths[24*i+23:24*i]. A nearer new value overwrites a farther old one.
- R4: An update accepted at clock edge n is written at edge n+4. A query accepted at edge n+5 or later sees the new value.
- R5: qry_ready is low while the queried tile matches an update in the reduction pipeline, or an update presented in the same cycle. It returns high once that write has committed.
- R6: res_valid pulses in the cycle after a query is accepted (qry_valid and qry_ready at an edge), and res_tile repeats the query's tile. A query that is not accepted produces no result.
- R7: clear is synchronous. It resets all 64 entries to the far value, discards every in-flight update and any update presented with it, and holds qry_ready low.
- R8: The 64 entries, indexed by a 6-bit tile number from 0 to 63, are independent. An update to one tile leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous reset of all entries to far, flushes the update pipeline |
| upd_valid | input | 1 | Tile update present |
| upd_tile | input | 6 | Tile number of the update |
| upd_depths | input | 384 | Sixteen 24-bit depths, lane i at bits 24*i+23:24*i |
| qry_valid | input | 1 | Cull query present |
| qry_tile | input | 6 | Tile number of the query |
| qry_min_depth | input | 24 | Nearest depth of the incoming block |
| qry_ready | output | 1 | Query accepted at this edge when high |
| res_valid | output | 1 | Cull result present |
| res_reject | output | 1 | High when the whole tile is hidden |
| res_tile | output | 6 | Tile number of the result |

## Verification
Random updates aimed at a few crowded tiles drive the stall logic and back-to-back writes to one entry. The same run uses spread-out tiles to show that entries stay independent. Query depths set to the stored value, and one above it, separate a strict compare from a non-strict one. A lane-by-lane sweep that places the maximum in each of the sixteen positions finds any tree node that is miswired. Queries issued on every cycle after an update pin down the commit edge. A clear issued while updates are in flight shows that pending writes are dropped and not applied late.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int HZ_DEPTH_W = 24;
  typedef logic [HZ_DEPTH_W-1:0] depth_t;
  localparam depth_t HZ_FAR = '1;

  // farther of two depths (larger value is farther)
  function automatic depth_t hz_farther(input depth_t a, input depth_t b);
    return (a > b) ? a : b;
  endfunction

  // whole block hidden when its nearest point lies behind the stored farthest point
  function automatic logic hz_hidden(input depth_t blk_min, input depth_t stored_far);
    return blk_min > stored_far;
  endfunction
endpackage

// File: rtl/hz_max_tree.sv
module hz_max_tree
  import hz_pkg::*;
#(
  parameter int LANES = 16,
  parameter int IDX_W = 6,
  localparam int LVLS = $clog2(LANES),
  localparam int DW   = HZ_DEPTH_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  in_valid,
  input  logic [IDX_W-1:0]      in_tile,
  input  logic [LANES*DW-1:0]   in_depths,
  output logic [LVLS-1:0]       stage_v,
  output logic [LVLS*IDX_W-1:0] stage_t,
  output logic                  out_valid,
  output logic [IDX_W-1:0]      out_tile,
  output depth_t                out_depth
);
  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int CNT = LANES >> (l + 1);
    depth_t           src [2*CNT];
    logic             src_v;
    logic [IDX_W-1:0] src_t;
    depth_t           d_q [CNT];
    logic             v_q;
    logic [IDX_W-1:0] t_q;

    if (l == 0) begin : g_src_in
      always_comb begin
        for (int i = 0; i < 2*CNT; i++) src[i] = in_depths[i*DW +: DW];
        src_v = in_valid;
        src_t = in_tile;
      end
    end else begin : g_src_prev
      always_comb begin
        for (int i = 0; i < 2*CNT; i++) src[i] = g_lvl[l-1].d_q[i];
        src_v = g_lvl[l-1].v_q;
        src_t = g_lvl[l-1].t_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     v_q <= 1'b0;
      else if (flush) v_q <= 1'b0;
      else            v_q <= src_v;
    end

    always_ff @(posedge clk) begin
      t_q <= src_t;
      for (int i = 0; i < CNT; i++) d_q[i] <= hz_farther(src[2*i], src[2*i+1]);
    end

    assign stage_v[l]               = v_q;
    assign stage_t[l*IDX_W +: IDX_W] = t_q;
  end

  assign out_valid = g_lvl[LVLS-1].v_q;
  assign out_tile  = g_lvl[LVLS-1].t_q;
  assign out_depth = g_lvl[LVLS-1].d_q[0];
endmodule

// File: rtl/hz_coarse_store.sv
module hz_coarse_store
  import hz_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  depth_t           wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output depth_t           rd_data
);
  depth_t ent_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= HZ_FAR;
    end else if (clear) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= HZ_FAR;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/hz_query_ctrl.sv
module hz_query_ctrl
  import hz_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int STAGES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    qry_valid,
  input  logic [IDX_W-1:0]        qry_tile,
  input  depth_t                  qry_min_depth,
  input  depth_t                  stored_far,
  input  logic                    upd_valid,
  input  logic [IDX_W-1:0]        upd_tile,
  input  logic [STAGES-1:0]       stage_v,
  input  logic [STAGES*IDX_W-1:0] stage_t,
  output logic                    hazard,
  output logic                    qry_ready,
  output logic                    res_valid,
  output logic                    res_reject,
  output logic [IDX_W-1:0]        res_tile
);
  logic [STAGES-1:0] stage_hit;
  logic              entry_hit;
  logic              accept;

  for (genvar s = 0; s < STAGES; s++) begin : g_hit
    assign stage_hit[s] = stage_v[s] && (stage_t[s*IDX_W +: IDX_W] == qry_tile);
  end

  assign entry_hit = upd_valid && (upd_tile == qry_tile);
  assign hazard    = entry_hit || (|stage_hit);
  assign qry_ready = !clear && !hazard;
  assign accept    = qry_valid && qry_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_reject <= 1'b0;
      res_tile   <= '0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_reject <= hz_hidden(qry_min_depth, stored_far);
        res_tile   <= qry_tile;
      end
    end
  end
endmodule

// File: rtl/hz_tile_cull.sv
module hz_tile_cull
  import hz_pkg::*;
#(
  parameter int TILES = 64,
  parameter int LANES = 16,
  localparam int IDX_W = $clog2(TILES),
  localparam int LVLS  = $clog2(LANES),
  localparam int DW    = HZ_DEPTH_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                upd_valid,
  input  logic [IDX_W-1:0]    upd_tile,
  input  logic [LANES*DW-1:0] upd_depths,
  input  logic                qry_valid,
  input  logic [IDX_W-1:0]    qry_tile,
  input  logic [DW-1:0]       qry_min_depth,
  output logic                qry_ready,
  output logic                res_valid,
  output logic                res_reject,
  output logic [IDX_W-1:0]    res_tile
);
  logic [LVLS-1:0]       stage_v;
  logic [LVLS*IDX_W-1:0] stage_t;
  logic                  wr_en;
  logic [IDX_W-1:0]      wr_tile;
  depth_t                wr_depth;
  depth_t                stored_far;
  logic                  hazard;

  hz_max_tree #(.LANES(LANES), .IDX_W(IDX_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .flush(clear),
    .in_valid(upd_valid), .in_tile(upd_tile), .in_depths(upd_depths),
    .stage_v(stage_v), .stage_t(stage_t),
    .out_valid(wr_en), .out_tile(wr_tile), .out_depth(wr_depth)
  );

  hz_coarse_store #(.ENTRIES(TILES)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .wr_en(wr_en), .wr_idx(wr_tile), .wr_data(wr_depth),
    .rd_idx(qry_tile), .rd_data(stored_far)
  );

  hz_query_ctrl #(.IDX_W(IDX_W), .STAGES(LVLS)) u_qry (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .qry_valid(qry_valid), .qry_tile(qry_tile), .qry_min_depth(qry_min_depth),
    .stored_far(stored_far),
    .upd_valid(upd_valid), .upd_tile(upd_tile),
    .stage_v(stage_v), .stage_t(stage_t),
    .hazard(hazard), .qry_ready(qry_ready),
    .res_valid(res_valid), .res_reject(res_reject), .res_tile(res_tile)
  );
endmodule

// File: rtl/hz_tile_cull_chk.sv
module hz_tile_cull_chk #(
  parameter int IDX_W = 6,
  parameter int DW = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             upd_valid,
  input logic             qry_valid,
  input logic [IDX_W-1:0] qry_tile,
  input logic [DW-1:0]    qry_min_depth,
  input logic             qry_ready,
  input logic             res_valid,
  input logic             res_reject,
  input logic [IDX_W-1:0] res_tile,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_tile,
  input logic             hazard
);
  a_r4_write_latency: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(upd_valid, 4));

  a_r5_no_stale_read: assert property (@(posedge clk) disable iff (!rst_n)
    $past(qry_valid && qry_ready && rst_n) |-> !(wr_en && (wr_tile == $past(qry_tile))));

  a_r6_result_timing: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(qry_valid && qry_ready && rst_n));

  a_r6_tile_echo: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_tile == $past(qry_tile)));

  a_r7_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !qry_ready);

  a_r5_hazard_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> !qry_ready);

  a_r2_zero_min_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(qry_min_depth) == '0)) |-> !res_reject);
endmodule

bind hz_tile_cull hz_tile_cull_chk #(.IDX_W(IDX_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .upd_valid(upd_valid),
  .qry_valid(qry_valid), .qry_tile(qry_tile), .qry_min_depth(qry_min_depth),
  .qry_ready(qry_ready), .res_valid(res_valid), .res_reject(res_reject),
  .res_tile(res_tile), .wr_en(wr_en), .wr_tile(wr_tile), .hazard(hazard)
);

// File: tb/hz_tile_cull_tb.sv
module hz_tile_cull_tb;
  localparam int CLK_P = 10;
  localparam int NT = 64;
  localparam int NL = 16;
  localparam int DW = 24;
  localparam logic [DW-1:0] FAR = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic upd_valid = 1'b0;
  logic [5:0] upd_tile = '0;
  logic [NL*DW-1:0] upd_depths = '0;
  logic qry_valid = 1'b0;
  logic [5:0] qry_tile = '0;
  logic [DW-1:0] qry_min_depth = '0;
  logic qry_ready, res_valid, res_reject;
  logic [5:0] res_tile;

  always #(CLK_P/2) clk = ~clk;

  hz_tile_cull u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .upd_valid(upd_valid), .upd_tile(upd_tile), .upd_depths(upd_depths),
    .qry_valid(qry_valid), .qry_tile(qry_tile), .qry_min_depth(qry_min_depth),
    .qry_ready(qry_ready), .res_valid(res_valid), .res_reject(res_reject),
    .res_tile(res_tile)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [DW-1:0] mdl [NT];
  bit            pend_v [16];
  logic [5:0]    pend_t [16];
  logic [DW-1:0] pend_d [16];
  int            pend_e [16];
  int            edge_n = 0;
  bit            exp_rv = 0, exp_rj = 0;
  logic [5:0]    exp_rt = '0;

  function automatic logic [DW-1:0] lane_max(input logic [NL*DW-1:0] v);
    logic [DW-1:0] m = '0;
    for (int i = 0; i < NL; i++) if (v[i*DW +: DW] >= m) m = v[i*DW +: DW];
    return m;
  endfunction

  function automatic bit exp_blocked(input bit cl, input bit uv, input logic [5:0] ut,
                                     input logic [5:0] qt);
    if (cl) return 1;
    if (uv && ut == qt) return 1;
    for (int i = 0; i < 16; i++) if (pend_v[i] && pend_t[i] == qt && pend_e[i] >= edge_n) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, edge_n);
    end
  endtask

  task automatic cyc(input bit cl, input bit uv, input logic [5:0] ut,
                     input logic [NL*DW-1:0] ud, input bit qv, input logic [5:0] qt,
                     input logic [DW-1:0] qm);
    bit eb, acc;
    @(negedge clk);
    chk(res_valid == exp_rv, "R6 res_valid", res_valid, exp_rv);
    if (exp_rv) begin
      chk(res_tile == exp_rt, "R6 res_tile", res_tile, exp_rt);
      chk(res_reject == exp_rj, "R2 res_reject", res_reject, exp_rj);
    end
    clear = cl; upd_valid = uv; upd_tile = ut; upd_depths = ud;
    qry_valid = qv; qry_tile = qt; qry_min_depth = qm;
    #1;
    eb = exp_blocked(cl, uv, ut, qt);
    chk(qry_ready == !eb, cl ? "R7 ready in clear" : "R5 qry_ready", qry_ready, !eb);
    acc = qv && !eb;
    exp_rv = acc;
    if (acc) begin exp_rt = qt; exp_rj = (qm > mdl[qt]); end
    @(posedge clk);
    if (cl) begin
      for (int i = 0; i < NT; i++) mdl[i] = FAR;
      for (int i = 0; i < 16; i++) pend_v[i] = 0;
    end else begin
      for (int i = 0; i < 16; i++)
        if (pend_v[i] && pend_e[i] == edge_n) begin mdl[pend_t[i]] = pend_d[i]; pend_v[i] = 0; end
      if (uv) begin
        for (int i = 0; i < 16; i++)
          if (!pend_v[i]) begin
            pend_v[i] = 1; pend_t[i] = ut; pend_d[i] = lane_max(ud); pend_e[i] = edge_n + 4;
            break;
          end
      end
    end
    edge_n++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, '0, '0, 0, '0, '0);
  endtask

  function automatic logic [NL*DW-1:0] fill(input logic [DW-1:0] base, input int hot,
                                            input logic [DW-1:0] hv);
    logic [NL*DW-1:0] v;
    for (int i = 0; i < NL; i++) v[i*DW +: DW] = (i == hot) ? hv : base - DW'(i);
    return v;
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NL*DW-1:0] v;
    int seed;
    seed = 32'h1F2E3D;
    void'($urandom(seed));
    for (int i = 0; i < NT; i++) mdl[i] = FAR;
    for (int i = 0; i < 16; i++) pend_v[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(res_valid == 0, "R1 res_valid after reset", res_valid, 0);
    rst_n = 1'b1;
    // R1: far entries never reject, even the largest min
    cyc(0, 0, 0, 0, 1, 6'd0, FAR);
    cyc(0, 0, 0, 0, 1, 6'd63, FAR);
    // R3 lane sweep: max in each lane, query at max+1 (reject) and max (accept)
    for (int h = 0; h < NL; h++) begin
      v = fill(24'h000100, h, 24'h004000 + DW'(h));
      cyc(0, 1, 6'd5, v, 0, 0, 0);
      idle(4);
      cyc(0, 0, 0, 0, 1, 6'd5, 24'h004001 + DW'(h)); // R2 strictly greater -> reject
      cyc(0, 0, 0, 0, 1, 6'd5, 24'h004000 + DW'(h)); // R2 equal -> accept
    end
    // R3 nearer value overwrites farther one
    cyc(0, 1, 6'd5, fill(24'h000050, 0, 24'h000060), 0, 0, 0);
    idle(4);
    cyc(0, 0, 0, 0, 1, 6'd5, 24'h000061);
    // R4 / R5: query every cycle right after an update to the same tile
    cyc(0, 1, 6'd63, fill(24'h000200, 3, 24'h000300), 1, 6'd63, 24'h000400);
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 1, 6'd63, 24'h000400);
    // R8: other tile unaffected by tile 63 update
    cyc(0, 0, 0, 0, 1, 6'd62, FAR);
    // R7: clear with updates in flight and one presented with it
    cyc(0, 1, 6'd9, fill(24'h10, 0, 24'h20), 0, 0, 0);
    cyc(0, 1, 6'd10, fill(24'h10, 0, 24'h20), 0, 0, 0);
    cyc(1, 1, 6'd11, fill(24'h10, 0, 24'h20), 1, 6'd9, 24'h30);
    idle(5);
    cyc(0, 0, 0, 0, 1, 6'd9, 24'h30);
    cyc(0, 0, 0, 0, 1, 6'd10, 24'h30);
    cyc(0, 0, 0, 0, 1, 6'd11, 24'h30);
    cyc(0, 0, 0, 0, 1, 6'd5, FAR);
    // random mix over a few hot tiles and a spread
    for (int k = 0; k < 3000; k++) begin
      bit cl, uv, qv;
      logic [5:0] ut, qt;
      logic [DW-1:0] base;
      cl = ($urandom % 200) == 0;
      uv = ($urandom % 3) == 0;
      qv = ($urandom % 4) != 0;
      ut = ($urandom % 2) ? 6'($urandom % 4) : 6'($urandom);
      qt = ($urandom % 2) ? 6'($urandom % 4) : 6'($urandom);
      base = DW'($urandom % 4096) + 24'd64;
      for (int i = 0; i < NL; i++) v[i*DW +: DW] = base - DW'($urandom % 64);
      cyc(cl, uv, ut, v, qv, qt, base - DW'(32) + DW'($urandom % 64));
    end
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule